// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block decides, for a load that is about to execute, whether its data can be taken from an older store still waiting in the store queue. The scan starts at the youngest store older than the load and moves toward older entries. At each entry it compares the load's byte range with the store's byte range. The first store in that order that settles the case decides the outcome, which is one of four:

- The load is forwarded from that store, with its data aligned.
- The load is stalled because only part of its data is in that store.
- The load is sent to memory because no store supplies its data.
- The load is retried because it is uncacheable and not yet allowed to run.

The scan window covers every store-queue slot from the load's store index back to the store writeback index, both included, with wraparound. All slots are compared in parallel. An age-ordered priority pick then selects the deciding entry. The outcome is registered, so every result appears exactly one cycle after the load is presented. For a forwarded load this is the one-cycle forwarding latency.

Top module: `store_load_fwd`

## Requirements
- R1: After reset all four outcome flags are low. A load presented with `ld_valid_i` high in one cycle produces exactly one of `fwd_valid_o`, `stall_valid_o`, `mem_req_o`, `retry_o` high in the next cycle. When no load was presented, all four flags are low.
- R2: A load with `ld_uncached_i` high is answered with `retry_o` unless both `ld_at_head_i` and `ld_committed_i` are high. A load with `ld_uncached_i` high that has both of those set is checked like any other load.
- R3: The scan visits slots idx = (`ld_sq_idx_i` − k) mod SQ_DEPTH for k = 0 .. d, where d = (`ld_sq_idx_i` − `sq_wb_idx_i`) mod SQ_DEPTH. Slots outside this window never affect the outcome.
- R4: A slot whose size field is 0 is empty and is skipped, whatever its address.
- R5: The first slot in scan order (smallest k) that forwards or stalls decides the outcome. Older matching slots are ignored.
- R6: A slot fully contains the load when load_addr ≥ store_addr and load_addr + load_size ≤ store_addr + store_size. Such a slot forwards: `fwd_data_o` = store_data >> (8 × (load_addr & (store_size − 1))), with all bytes at or above load_size cleared to zero.
- R7: A slot whose range intersects the load's range without containing it stalls the load if its done bit is 0. `stall_idx_o` gives that slot's index.
- R8: A partial overlap with a slot whose done bit is 1 is skipped, and the scan continues with the next older slot.
- R9: When no slot in the window forwards or stalls, the load is sent to memory (`mem_req_o`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | A load is presented this cycle |
| ld_addr_i | input | ADDR_W | Load byte address |
| ld_size_i | input | SIZE_W | Load size in bytes (1, 2, 4, 8) |
| ld_sq_idx_i | input | IDX_W | Youngest store slot older than the load; scan start |
| sq_wb_idx_i | input | IDX_W | Store writeback index; oldest slot scanned |
| ld_uncached_i | input | 1 | Load targets uncacheable memory |
| ld_at_head_i | input | 1 | Load sits at the load queue head |
| ld_committed_i | input | 1 | Load has reached commit |
| st_addr_i | input | SQ_DEPTH*ADDR_W | Store addresses, slot n at bits n*ADDR_W |
| st_size_i | input | SQ_DEPTH*SIZE_W | Store sizes in bytes, 0 means empty slot |
| st_data_i | input | SQ_DEPTH*DATA_W | Store data, byte 0 in the low bits |
| st_done_i | input | SQ_DEPTH | Store already completed to memory |
| fwd_valid_o | output | 1 | Load is forwarded |
| fwd_data_o | output | DATA_W | Forwarded, aligned and masked data |
| stall_valid_o | output | 1 | Load stalls on a partial overlap |
| stall_idx_o | output | IDX_W | Slot index that caused the stall |
| mem_req_o | output | 1 | Load is sent to memory |
| retry_o | output | 1 | Uncacheable load is rejected for a later retry |

## Verification
The assertions and the forwarding shift rely on several assumptions about the inputs:

- Every non-zero size is a power of two no larger than the data width in bytes.
- Every load and store address is aligned to its own size.
- The depth is a power of two, so index arithmetic wraps on its own.

Under these assumptions, full containment always means the load lies within one naturally aligned store word. The stimulus only builds aligned, power-of-two accesses. The offset sweep moves a load of each size across every aligned position around a store of each size, with the done bit both clear and set. Directed cases then place stores at the window edges, across the wrap, in empty slots and in competing positions.

// File: rtl/lsf_pkg.sv
package lsf_pkg;

    // Per-slot verdict of the range comparison
    typedef enum logic [1:0] {
        CLS_SKIP  = 2'd0,
        CLS_FWD   = 2'd1,
        CLS_STALL = 2'd2
    } match_e;

endpackage

// File: rtl/lsf_entry_cmp.sv
module lsf_entry_cmp #(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 4
) (
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic [SIZE_W-1:0] ld_size_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic [SIZE_W-1:0] st_size_i,
    input  logic              st_done_i,
    output lsf_pkg::match_e   cls_o
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] ld_lo, ld_hi, st_lo, st_hi;
    logic             overlap, contain;

    always_comb begin
        ld_lo   = {1'b0, ld_addr_i};
        ld_hi   = ld_lo + EXT_W'(ld_size_i);
        st_lo   = {1'b0, st_addr_i};
        st_hi   = st_lo + EXT_W'(st_size_i);
        overlap = (ld_lo < st_hi) && (st_lo < ld_hi);
        contain = (ld_lo >= st_lo) && (ld_hi <= st_hi);
        cls_o   = lsf_pkg::CLS_SKIP;
        if (st_size_i != '0) begin
            if (contain) begin
                cls_o = lsf_pkg::CLS_FWD;
            end else if (overlap && !st_done_i) begin
                cls_o = lsf_pkg::CLS_STALL;
            end
        end
    end
endmodule

// File: rtl/lsf_age_pick.sv
module lsf_age_pick #(
    parameter int SQ_DEPTH = 8,
    localparam int IDX_W   = $clog2(SQ_DEPTH)
) (
    input  lsf_pkg::match_e   cls_i [SQ_DEPTH],
    input  logic [IDX_W-1:0]  start_i,
    input  logic [IDX_W-1:0]  stop_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  hit_idx_o,
    output lsf_pkg::match_e   hit_cls_o
);
    logic [IDX_W-1:0] span;
    logic [IDX_W-1:0] step;
    logic [IDX_W-1:0] pos;

    // Youngest-first walk: step 0 is the scan start, larger steps are older
    always_comb begin
        span      = start_i - stop_i;
        hit_o     = 1'b0;
        hit_idx_o = '0;
        hit_cls_o = lsf_pkg::CLS_SKIP;
        step      = '0;
        pos       = '0;
        for (int k = 0; k < SQ_DEPTH; k++) begin
            step = IDX_W'(k);
            pos  = start_i - step;
            if (!hit_o && (step <= span) && (cls_i[pos] != lsf_pkg::CLS_SKIP)) begin
                hit_o     = 1'b1;
                hit_idx_o = pos;
                hit_cls_o = cls_i[pos];
            end
        end
    end
endmodule

// File: rtl/lsf_data_align.sv
module lsf_data_align #(
    parameter int DATA_W     = 64,
    parameter int ADDR_W     = 16,
    parameter int SIZE_W     = 4,
    localparam int DATA_BYTES = DATA_W / 8,
    localparam int OFF_W      = $clog2(DATA_BYTES)
) (
    input  logic [DATA_W-1:0] st_data_i,
    input  logic [SIZE_W-1:0] st_size_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic [SIZE_W-1:0] ld_size_i,
    output logic [DATA_W-1:0] data_o
);
    logic [OFF_W-1:0]  byte_off;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        byte_off = ld_addr_i[OFF_W-1:0] & (st_size_i[OFF_W-1:0] - OFF_W'(1));
        shifted  = st_data_i >> {byte_off, 3'b000};
        data_o   = '0;
        for (int b = 0; b < DATA_BYTES; b++) begin
            if (SIZE_W'(b) < ld_size_i) begin
                data_o[b*8 +: 8] = shifted[b*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/store_load_fwd.sv
module store_load_fwd #(
    parameter int SQ_DEPTH = 8,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 64,
    localparam int IDX_W      = $clog2(SQ_DEPTH),
    localparam int SIZE_W     = $clog2(DATA_W / 8) + 1
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       ld_valid_i,
    input  logic [ADDR_W-1:0]          ld_addr_i,
    input  logic [SIZE_W-1:0]          ld_size_i,
    input  logic [IDX_W-1:0]           ld_sq_idx_i,
    input  logic [IDX_W-1:0]           sq_wb_idx_i,
    input  logic                       ld_uncached_i,
    input  logic                       ld_at_head_i,
    input  logic                       ld_committed_i,
    input  logic [SQ_DEPTH*ADDR_W-1:0] st_addr_i,
    input  logic [SQ_DEPTH*SIZE_W-1:0] st_size_i,
    input  logic [SQ_DEPTH*DATA_W-1:0] st_data_i,
    input  logic [SQ_DEPTH-1:0]        st_done_i,
    output logic                       fwd_valid_o,
    output logic [DATA_W-1:0]          fwd_data_o,
    output logic                       stall_valid_o,
    output logic [IDX_W-1:0]           stall_idx_o,
    output logic                       mem_req_o,
    output logic                       retry_o
);
    typedef struct packed {
        logic              fwd_v;
        logic [DATA_W-1:0] fwd_data;
        logic              stall_v;
        logic [IDX_W-1:0]  stall_idx;
        logic              mem_v;
        logic              retry_v;
    } res_t;

    logic [ADDR_W-1:0] slot_addr [SQ_DEPTH];
    logic [SIZE_W-1:0] slot_size [SQ_DEPTH];
    logic [DATA_W-1:0] slot_data [SQ_DEPTH];
    lsf_pkg::match_e   slot_cls  [SQ_DEPTH];

    for (genvar g = 0; g < SQ_DEPTH; g++) begin : g_slot
        assign slot_addr[g] = st_addr_i[g*ADDR_W +: ADDR_W];
        assign slot_size[g] = st_size_i[g*SIZE_W +: SIZE_W];
        assign slot_data[g] = st_data_i[g*DATA_W +: DATA_W];

        lsf_entry_cmp #(
            .ADDR_W (ADDR_W),
            .SIZE_W (SIZE_W)
        ) u_cmp (
            .ld_addr_i (ld_addr_i),
            .ld_size_i (ld_size_i),
            .st_addr_i (slot_addr[g]),
            .st_size_i (slot_size[g]),
            .st_done_i (st_done_i[g]),
            .cls_o     (slot_cls[g])
        );
    end

    logic              pick_hit;
    logic [IDX_W-1:0]  pick_idx;
    lsf_pkg::match_e   pick_cls;

    lsf_age_pick #(
        .SQ_DEPTH (SQ_DEPTH)
    ) u_pick (
        .cls_i     (slot_cls),
        .start_i   (ld_sq_idx_i),
        .stop_i    (sq_wb_idx_i),
        .hit_o     (pick_hit),
        .hit_idx_o (pick_idx),
        .hit_cls_o (pick_cls)
    );

    logic [DATA_W-1:0] aligned_data;

    // One aligner after the slot mux, fed by the winning slot only
    lsf_data_align #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W)
    ) u_align (
        .st_data_i (slot_data[pick_idx]),
        .st_size_i (slot_size[pick_idx]),
        .ld_addr_i (ld_addr_i),
        .ld_size_i (ld_size_i),
        .data_o    (aligned_data)
    );

    res_t res_d, res_q;
    logic uc_blocked;

    always_comb begin
        res_d      = '0;
        uc_blocked = ld_uncached_i && !(ld_at_head_i && ld_committed_i);
        if (ld_valid_i) begin
            if (uc_blocked) begin
                res_d.retry_v = 1'b1;
            end else if (pick_hit && (pick_cls == lsf_pkg::CLS_FWD)) begin
                res_d.fwd_v    = 1'b1;
                res_d.fwd_data = aligned_data;
            end else if (pick_hit && (pick_cls == lsf_pkg::CLS_STALL)) begin
                res_d.stall_v   = 1'b1;
                res_d.stall_idx = pick_idx;
            end else begin
                res_d.mem_v = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign fwd_valid_o   = res_q.fwd_v;
    assign fwd_data_o    = res_q.fwd_data;
    assign stall_valid_o = res_q.stall_v;
    assign stall_idx_o   = res_q.stall_idx;
    assign mem_req_o     = res_q.mem_v;
    assign retry_o       = res_q.retry_v;
endmodule

// File: rtl/store_load_fwd_chk.sv
module store_load_fwd_chk #(
    parameter int SQ_DEPTH = 8,
    parameter int IDX_W    = 3,
    parameter int SIZE_W   = 4
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic                       ld_valid_i,
    input logic                       ld_uncached_i,
    input logic                       ld_at_head_i,
    input logic                       ld_committed_i,
    input logic [SQ_DEPTH*SIZE_W-1:0] st_size_i,
    input logic [SQ_DEPTH-1:0]        st_done_i,
    input logic                       fwd_valid_o,
    input logic                       stall_valid_o,
    input logic [IDX_W-1:0]           stall_idx_o,
    input logic                       mem_req_o,
    input logic                       retry_o
);
    logic [SQ_DEPTH-1:0]        done_prev;
    logic [SQ_DEPTH*SIZE_W-1:0] size_prev;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            done_prev <= '0;
            size_prev <= '0;
        end else begin
            done_prev <= st_done_i;
            size_prev <= st_size_i;
        end
    end

    logic any_out;
    assign any_out = fwd_valid_o | stall_valid_o | mem_req_o | retry_o;

    assert_single_outcome_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({fwd_valid_o, stall_valid_o, mem_req_o, retry_o}));

    assert_result_needs_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_out |-> $past(ld_valid_i));

    assert_load_gets_result_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_valid_i |=> any_out);

    assert_retry_only_blocked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retry_o |-> $past(ld_uncached_i && !(ld_at_head_i && ld_committed_i)));

    assert_stall_on_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_valid_o |-> !done_prev[stall_idx_o]);

    assert_stall_not_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_valid_o |-> (size_prev[stall_idx_o*SIZE_W +: SIZE_W] != '0));
endmodule

bind store_load_fwd store_load_fwd_chk #(
    .SQ_DEPTH (SQ_DEPTH),
    .IDX_W    (IDX_W),
    .SIZE_W   (SIZE_W)
) i_store_load_fwd_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ld_valid_i     (ld_valid_i),
    .ld_uncached_i  (ld_uncached_i),
    .ld_at_head_i   (ld_at_head_i),
    .ld_committed_i (ld_committed_i),
    .st_size_i      (st_size_i),
    .st_done_i      (st_done_i),
    .fwd_valid_o    (fwd_valid_o),
    .stall_valid_o  (stall_valid_o),
    .stall_idx_o    (stall_idx_o),
    .mem_req_o      (mem_req_o),
    .retry_o        (retry_o)
);

// File: tb/test_store_load_fwd.sv
`timescale 1ns/1ps
module test_store_load_fwd;
    localparam int N  = 8;
    localparam int AW = 16;
    localparam int DW = 64;
    localparam int IW = 3;
    localparam int SW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ld_valid = 1'b0;
    logic [AW-1:0]  ld_addr = '0;
    logic [SW-1:0]  ld_size = '0;
    logic [IW-1:0]  ld_sq_idx = '0;
    logic [IW-1:0]  wb_idx = '0;
    logic           ld_unc = 1'b0, ld_head = 1'b0, ld_com = 1'b0;
    logic [N*AW-1:0] st_addr;
    logic [N*SW-1:0] st_size;
    logic [N*DW-1:0] st_data;
    logic [N-1:0]    st_done;
    logic            fwd_v, stall_v, mem_v, retry_v;
    logic [DW-1:0]   fwd_data;
    logic [IW-1:0]   stall_idx;

    int          m_addr [N];
    int          m_size [N];
    logic [DW-1:0] m_data [N];
    bit          m_done [N];

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            st_addr[i*AW +: AW] = AW'(m_addr[i]);
            st_size[i*SW +: SW] = SW'(m_size[i]);
            st_data[i*DW +: DW] = m_data[i];
            st_done[i]          = m_done[i];
        end
    end

    store_load_fwd #(.SQ_DEPTH(N), .ADDR_W(AW), .DATA_W(DW)) i_store_load_fwd (
        .clk_i (clk), .rst_ni (rst_n), .ld_valid_i (ld_valid),
        .ld_addr_i (ld_addr), .ld_size_i (ld_size), .ld_sq_idx_i (ld_sq_idx),
        .sq_wb_idx_i (wb_idx), .ld_uncached_i (ld_unc), .ld_at_head_i (ld_head),
        .ld_committed_i (ld_com), .st_addr_i (st_addr), .st_size_i (st_size),
        .st_data_i (st_data), .st_done_i (st_done), .fwd_valid_o (fwd_v),
        .fwd_data_o (fwd_data), .stall_valid_o (stall_v), .stall_idx_o (stall_idx),
        .mem_req_o (mem_v), .retry_o (retry_v)
    );

    task automatic clear_slots();
        for (int i = 0; i < N; i++) begin
            m_addr[i] = 0; m_size[i] = 0; m_done[i] = 1'b0;
            m_data[i] = {8{8'(8'h11 * (i + 1))}} ^ 64'h0706050403020100;
        end
    endtask

    // Expected outcome from the requirements: 0 mem, 1 fwd, 2 stall, 3 retry
    task automatic model(input int la, lsz, start, wb, input bit unc, head, com,
                         output int kind, output logic [DW-1:0] data, output int idx);
        int span;
        kind = 0; data = '0; idx = 0;
        if (unc && !(head && com)) begin
            kind = 3;
            return;
        end
        span = (start - wb + N) % N;
        for (int k = 0; k <= span; k++) begin
            int s;
            s = (start - k + N) % N;
            if (m_size[s] == 0) continue;
            if (la >= m_addr[s] && la + lsz <= m_addr[s] + m_size[s]) begin
                kind = 1;
                for (int b = 0; b < lsz; b++)
                    data[b*8 +: 8] = m_data[s][(la - m_addr[s] + b)*8 +: 8];
                idx = s;
                return;
            end
            if (la < m_addr[s] + m_size[s] && m_addr[s] < la + lsz && !m_done[s]) begin
                kind = 2;
                idx = s;
                return;
            end
        end
    endtask

    task automatic run_load(input string tag, input int la, lsz, start, wb,
                            input bit unc, head, com);
        int exp_kind, exp_idx;
        logic [DW-1:0] exp_data;
        bit bad;
        model(la, lsz, start, wb, unc, head, com, exp_kind, exp_data, exp_idx);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = AW'(la); ld_size = SW'(lsz);
        ld_sq_idx = IW'(start); wb_idx = IW'(wb);
        ld_unc = unc; ld_head = head; ld_com = com;
        @(negedge clk);
        ld_valid = 1'b0;
        checks++;
        bad = (fwd_v != (exp_kind == 1)) || (stall_v != (exp_kind == 2)) ||
              (mem_v != (exp_kind == 0)) || (retry_v != (exp_kind == 3));
        if (!bad && exp_kind == 1 && fwd_data != exp_data) bad = 1'b1;
        if (!bad && exp_kind == 2 && stall_idx != IW'(exp_idx)) bad = 1'b1;
        if (bad) begin
            errors++;
            $display("FAIL %s addr=%0h size=%0d: got fwd=%0b stall=%0b mem=%0b retry=%0b data=%h idx=%0d expected kind=%0d data=%h idx=%0d",
                     tag, la, lsz, fwd_v, stall_v, mem_v, retry_v, fwd_data, stall_idx,
                     exp_kind, exp_data, exp_idx);
        end
    endtask

    task automatic check_idle(input string tag);
        checks++;
        if (fwd_v || stall_v || mem_v || retry_v) begin
            errors++;
            $display("FAIL %s idle flags fwd=%0b stall=%0b mem=%0b retry=%0b expected all 0",
                     tag, fwd_v, stall_v, mem_v, retry_v);
        end
    endtask

    initial begin
        #(20.0 * 200000);
        errors++;
        $display("FAIL watchdog expired: got hang expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_slots();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 reset state");

        // R6 R7 R8 R9: one store in a one-slot window, every aligned load position
        for (int si = 0; si < 4; si++) begin
            for (int li = 0; li < 4; li++) begin
                for (int dn = 0; dn < 2; dn++) begin
                    for (int off = -16; off < 16; off += (1 << li)) begin
                        clear_slots();
                        m_addr[3] = 'h40; m_size[3] = 1 << si; m_done[3] = dn[0];
                        run_load("R6/R7/R8/R9 sweep", 'h40 + off, 1 << li, 3, 3, 0, 0, 0);
                    end
                end
            end
        end

        // R1: a store that would match, but no load presented
        clear_slots();
        m_addr[2] = 'h80; m_size[2] = 8;
        @(negedge clk); @(negedge clk);
        check_idle("R1 no load");

        // R4: empty slot with a matching address is skipped
        clear_slots();
        m_addr[5] = 'h80; m_size[5] = 0;
        run_load("R4 empty slot", 'h80, 4, 5, 2, 0, 0, 0);

        // R3: slot older than the writeback index is outside the window
        clear_slots();
        m_addr[1] = 'h80; m_size[1] = 8;
        run_load("R3 outside window", 'h80, 4, 4, 2, 0, 0, 0);
        // R3: writeback slot itself is inside
        m_addr[2] = 'h88; m_size[2] = 8;
        run_load("R3 writeback slot", 'h8C, 4, 4, 2, 0, 0, 0);
        // R3: window wraps from 1 back through 0 to 6
        clear_slots();
        m_addr[7] = 'h100; m_size[7] = 8;
        run_load("R3 wrap window", 'h104, 2, 1, 6, 0, 0, 0);
        run_load("R3 wrap excluded", 'h104, 2, 1, 0, 0, 0, 0);

        // R5: younger containing store wins over older one
        clear_slots();
        m_addr[4] = 'h200; m_size[4] = 8;
        m_addr[3] = 'h200; m_size[3] = 4;
        run_load("R5 younger forwards", 'h200, 2, 4, 1, 0, 0, 0);
        // R5: younger partial overlap stalls even though older one contains
        m_size[4] = 2; m_addr[4] = 'h202; m_addr[3] = 'h200; m_size[3] = 8;
        run_load("R5 younger stalls", 'h200, 4, 4, 1, 0, 0, 0);
        // R8: younger partial overlap done, older contains -> forward
        m_done[4] = 1'b1;
        run_load("R8 skip done overlap", 'h200, 4, 4, 1, 0, 0, 0);

        // R2: uncacheable handling
        clear_slots();
        m_addr[6] = 'h300; m_size[6] = 8;
        run_load("R2 uncached not head", 'h300, 8, 6, 6, 1, 0, 1);
        run_load("R2 uncached not committed", 'h300, 8, 6, 6, 1, 1, 0);
        run_load("R2 uncached allowed", 'h304, 4, 6, 6, 1, 1, 1);
        run_load("R9 uncached allowed to memory", 'h400, 4, 6, 6, 1, 1, 1);

        // R1: back-to-back loads each yield one result
        run_load("R1 back to back a", 'h300, 1, 6, 6, 0, 0, 0);
        run_load("R1 back to back b", 'h500, 1, 6, 6, 0, 0, 0);
        @(negedge clk);
        check_idle("R1 after load");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule